// File: doc/BRIEF.md
# RS-485 Direction Turn-Around Controller

This block drives the driver-enable pin of a half-duplex RS-485 transceiver from the state of a UART transmitter. When automatic direction control is on, the block enters transmit state as soon as a character is waiting or being shifted out. It holds that state until the transmitter has been idle for a programmed number of bit times after the final stop bit, and then returns the line to receive. The extra hold keeps the driver on long enough for the last edge to settle on a long cable before other nodes reply.

The hold length is a 4-bit count of bit times, from 0 to 15. It is written through a narrow write port. A write lands only while the enhanced-feature enable input is high. The value cannot be read back, because its address returns modem status, which is decoded elsewhere. Bit time comes from the same tick that paces the serializer. When automatic control is off, software drives the pin directly. A polarity input lets the pin drive either an active-high or an active-low enable.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the hold count is 0 and the block is in receive state, so `dir_out` equals `pol_inv`.
- R2: With `auto_en` high, a pending character (`thr_empty` low) puts the block in transmit state from the next clock edge, even if the serializer has not started.
- R3: With `auto_en` high, transmit state holds for as long as `tx_busy` is high or `thr_empty` is low.
- R4: Once the transmitter is idle (`tx_busy` low and `thr_empty` high), the block returns to receive state at the edge that samples the (D+1)-th `bit_tick`, where D is the stored hold count. With D = 0, this is the first tick after the last stop bit.
- R5: A character that becomes pending while the hold is counting cancels the count and keeps transmit state. The full hold is counted again after that character ends.
- R6: A write (`wr_en` high) stores `wr_delay` as the hold count only while `enh_en` is high. A write while `enh_en` is low leaves the previous count in force.
- R7: With `auto_en` low, `dir_out` follows `sw_dir ^ pol_inv` and the automatic state is cleared. When `auto_en` rises, the block starts in receive state.
- R8: Transmit state drives `dir_out` to `~pol_inv` and receive state drives it to `pol_inv`. With `pol_inv` = 1, `dir_out` is an active-low enable.
- R9: The hold count advances only on clock edges where `bit_tick` is high. Without ticks, an idle transmitter never releases transmit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| tx_busy | input | 1 | Serializer is shifting a character, from start bit to the end of the stop bit |
| thr_empty | input | 1 | Transmit holding register empty; low when a character waits |
| auto_en | input | 1 | Automatic direction control enable |
| sw_dir | input | 1 | Software direction value used when `auto_en` is low |
| pol_inv | input | 1 | Output polarity select; 1 makes `dir_out` active low |
| enh_en | input | 1 | Enhanced-feature enable that gates writes to the hold count |
| wr_en | input | 1 | Write strobe for the hold count |
| wr_delay | input | DLY_W | Hold count value, in bit times |
| dir_out | output | 1 | Transceiver driver-enable output |

## Verification
The hold counter and the transmit flag are hidden state, and their only visible effect is the edge at which `dir_out` returns to receive. A counter that is off by one, a stored hold count that takes an ignored write, or a count that does not restart after cancellation therefore shows up as a release that comes a whole tick interval early or late, after the next idle period. A transmit flag that is stuck or left over from manual mode shows in the first cycle after `auto_en` rises or after a character is loaded. Because of this, the bench measures release against tick counts with several different stored values and tick spacings.

// File: rtl/rs485_dir_ctrl.sv
`timescale 1ns/1ps
module rs485_dir_ctrl #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_busy,
  input  logic             thr_empty,
  input  logic             auto_en,
  input  logic             sw_dir,
  input  logic             pol_inv,
  input  logic             enh_en,
  input  logic             wr_en,
  input  logic [DLY_W-1:0] wr_delay,
  output logic             dir_out
);

  logic [DLY_W-1:0] hold_q;
  logic [DLY_W-1:0] cnt_q;
  logic             xmit_q;

  wire pending  = tx_busy | ~thr_empty;
  wire hold_end = (cnt_q == hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (wr_en && enh_en) hold_q <= wr_delay;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xmit_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!auto_en || pending) begin
      xmit_q <= auto_en;
      cnt_q  <= '0;
    end else if (xmit_q && bit_tick) begin
      xmit_q <= ~hold_end;
      cnt_q  <= hold_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign dir_out = (auto_en ? xmit_q : sw_dir) ^ pol_inv;

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_busy,
  input logic thr_empty,
  input logic auto_en,
  input logic pol_inv,
  input logic dir_out
);

  wire xmit_seen = dir_out ^ pol_inv;

  p_pending_holds_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && (tx_busy || !thr_empty)) |=> (!auto_en || !$stable(pol_inv) || xmit_seen));

  p_auto_starts_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_en) |-> !xmit_seen);

  p_no_release_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !bit_tick && xmit_seen) |=> (!auto_en || !$stable(pol_inv) || xmit_seen));

  p_release_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && $past(auto_en) && $stable(pol_inv) && $fell(xmit_seen))
      |-> ($past(bit_tick) && $past(thr_empty) && !$past(tx_busy)));

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk chk_i (.*);

// File: tb/rs485_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;

  localparam int DLY_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, tx_busy = 0, thr_empty = 1, auto_en = 0;
  logic sw_dir = 0, pol_inv = 0, enh_en = 0, wr_en = 0;
  logic [DLY_W-1:0] wr_delay = '0;
  logic dir_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic m_xmit = 0;
  logic [DLY_W-1:0] m_cnt = '0, m_hold = '0;

  always #2.5 clk = ~clk;

  rs485_dir_ctrl #(.DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_busy(tx_busy),
    .thr_empty(thr_empty), .auto_en(auto_en), .sw_dir(sw_dir),
    .pol_inv(pol_inv), .enh_en(enh_en), .wr_en(wr_en),
    .wr_delay(wr_delay), .dir_out(dir_out)
  );

  function automatic logic exp_dir();
    return (auto_en ? m_xmit : sw_dir) ^ pol_inv;
  endfunction

  task automatic model_edge();
    if (!auto_en) begin
      m_xmit = 0; m_cnt = '0;
    end else if (tx_busy || !thr_empty) begin
      m_xmit = 1; m_cnt = '0;
    end else if (m_xmit && bit_tick) begin
      if (m_cnt == m_hold) begin m_xmit = 0; m_cnt = '0; end
      else m_cnt = m_cnt + 1'b1;
    end
    if (wr_en && enh_en) m_hold = wr_delay;
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dir_out=%0b expected=%0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1; model_edge();
    @(negedge clk);
    chk(tag, dir_out, exp_dir());
    bit_tick = 0; wr_en = 0;
  endtask

  task automatic send_char(input int busy_cycles, input string tag);
    thr_empty = 0; step(tag);
    thr_empty = 1; tx_busy = 1;
    for (int i = 0; i < busy_cycles; i++) begin bit_tick = (i % 3 == 0); step(tag); end
    tx_busy = 0;
  endtask

  task automatic ticks(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) step(tag);
      bit_tick = 1; step(tag);
    end
  endtask

  task automatic write_hold(input logic [DLY_W-1:0] v, input logic enh, input string tag);
    wr_en = 1; wr_delay = v; enh_en = enh; step(tag); enh_en = 0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1; n_fail++;
      $display("FAIL R4: watchdog expired, dir_out=%0b expected=finish", dir_out);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3D));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset receive", dir_out, 1'b0);

    auto_en = 1; step("R7 enable");
    chk("R7 starts receive", dir_out, 1'b0);
    thr_empty = 0; step("R2 pending");
    chk("R2 asserts before start bit", dir_out, 1'b1);
    thr_empty = 1; tx_busy = 1;
    for (int i = 0; i < 12; i++) begin bit_tick = (i % 4 == 0); step("R3 busy"); end
    chk("R3 held while busy", dir_out, 1'b1);
    tx_busy = 0; step("R4 idle");
    ticks(1, 2, "R4 zero hold");
    chk("R1 default hold 0 releases on first tick", dir_out, 1'b0);

    write_hold(4'd3, 1, "R6 write");
    send_char(9, "R3 char");
    ticks(3, 3, "R4 counting");
    chk("R4 still held after 3 ticks", dir_out, 1'b1);
    ticks(1, 3, "R4 release");
    chk("R4 released on 4th tick with hold 3", dir_out, 1'b0);

    write_hold(4'd9, 0, "R6 ignored write");
    send_char(6, "R6 char");
    ticks(4, 1, "R6 old hold");
    chk("R6 gated write ignored, hold 3 still used", dir_out, 1'b0);

    send_char(6, "R5 char");
    ticks(2, 2, "R5 partial");
    thr_empty = 0; step("R5 cancel");
    chk("R5 new char keeps transmit", dir_out, 1'b1);
    thr_empty = 1; tx_busy = 1;
    for (int i = 0; i < 5; i++) step("R5 busy");
    tx_busy = 0;
    ticks(3, 2, "R5 recount");
    chk("R5 full hold recounted", dir_out, 1'b1);
    ticks(1, 2, "R5 recount end");
    chk("R5 release after full hold", dir_out, 1'b0);

    write_hold(4'd15, 1, "R6 max");
    send_char(4, "R9 char");
    for (int i = 0; i < 40; i++) step("R9 no tick");
    chk("R9 no release without ticks", dir_out, 1'b1);
    ticks(16, 0, "R4 max hold");
    chk("R4 hold 15 releases on 16th tick", dir_out, 1'b0);

    auto_en = 0; sw_dir = 1; step("R7 manual");
    chk("R7 manual high", dir_out, 1'b1);
    sw_dir = 0; step("R7 manual");
    chk("R7 manual low", dir_out, 1'b0);
    pol_inv = 1; step("R8 manual inverted");
    chk("R8 inverted manual low", dir_out, 1'b1);
    auto_en = 1; step("R8 auto idle");
    chk("R8 inverted receive", dir_out, 1'b1);
    thr_empty = 0; step("R8 auto tx");
    chk("R8 inverted transmit", dir_out, 1'b0);
    thr_empty = 1; pol_inv = 0;
    write_hold(4'd0, 1, "R6 zero");

    for (int i = 0; i < 4000; i++) begin
      bit_tick = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) tx_busy = ~tx_busy;
      thr_empty = ($urandom % 16) != 0;
      if (($urandom % 96) == 0) auto_en = ~auto_en;
      if (($urandom % 256) == 0) pol_inv = ~pol_inv;
      sw_dir = $urandom % 2;
      enh_en = $urandom % 2;
      wr_en = ($urandom % 40) == 0;
      wr_delay = DLY_W'($urandom);
      step(auto_en ? "R4 random auto" : "R7 random manual");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule